// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block arbitrates eight interrupt request lines for a processor. Each cycle it takes the pending requests that are not masked and ranks them on a priority ring whose starting point is a rotation base. A request is forwarded to the processor only when it outranks every line already in service. When the processor acknowledges, the block marks the winning line as in service and returns the vector number for it. If nothing can win at that moment, it returns a spurious vector instead.

Software ends a service period with end-of-interrupt commands. A command can release the highest-ranked in-service line or a named line, and it can optionally move the rotation base past that line. A separate command moves the base without releasing anything. Automatic end-of-interrupt and rotation on automatic end-of-interrupt are selected by configuration inputs. A nested mode is provided for a primary controller that has a secondary controller cascaded on line 2. In that mode the in-service state of line 2 does not block new requests. Acknowledge and command must never be presented in the same cycle.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset, `isr_o` is 0, `base_o` is 0, `irq_o` is 0 and `vec_valid_o` is 0.
- R2: The rank of line i is (i - base_o) mod 8, where rank 0 is the highest. The candidate is the best-ranked line of `req_i & ~mask_i`, and masked lines never win.
- R3: `irq_o` is set one cycle after a cycle in which the candidate's rank is strictly better than the best rank in `isr_o`. Otherwise it is cleared.
- R4: While `nest_mode_i` is 1, in-service bit 2 is left out of the comparison of R3 and of the acknowledge decision.
- R5: `ack_i` with a valid candidate sets that line's bit in `isr_o`. In the next cycle, `vec_valid_o` is 1, `spurious_o` is 0 and `vec_o` = (`vec_base_i` & 0xF8) + line. `vec_valid_o` is 1 only in the cycle after an acknowledge.
- R6: `ack_i` without a valid candidate leaves `isr_o` unchanged. It gives `vec_o` = (`vec_base_i` & 0xF8) + 7 with `spurious_o` = 1.
- R7: With `auto_eoi_i` = 1, an acknowledge leaves the winner's bit clear in `isr_o`. If `rot_auto_eoi_i` is also 1, `base_o` becomes (line + 1) mod 8.
- R8: Command code 0 clears the best-ranked bit of `isr_o`. This ranking ignores `nest_mode_i`. With `isr_o` = 0 it changes nothing.
- R9: Command code 2 acts like code 0 and also sets `base_o` to (cleared line + 1) mod 8. With `isr_o` = 0 it changes nothing.
- R10: Command code 1 clears bit `cmd_line_i` of `isr_o`. Code 3 does the same and also sets `base_o` to (`cmd_line_i` + 1) mod 8.
- R11: Command code 4 sets `base_o` to (`cmd_line_i` + 1) mod 8 and leaves `isr_o` unchanged.
- R12: Command codes 5, 6 and 7 change neither `isr_o` nor `base_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request per line |
| mask_i | input | 8 | Per-line mask, 1 blocks the line |
| vec_base_i | input | 8 | Vector base; the low three bits are ignored |
| nest_mode_i | input | 1 | Nested mode for a cascaded secondary on line 2 |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_auto_eoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge pulse; never together with cmd_valid_i |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R8 to R12) |
| cmd_line_i | input | 3 | Line operand of commands |
| irq_o | output | 1 | Registered interrupt request to the processor |
| vec_valid_o | output | 1 | vec_o is fresh (cycle after acknowledge) |
| vec_o | output | 8 | Vector of the last acknowledge |
| spurious_o | output | 1 | Last acknowledge was spurious |
| isr_o | output | 8 | In-service bits |
| base_o | output | 3 | Rotation base (line of rank 0) |

## Verification
Rank state that has gone wrong shows up as a wrong line at the next acknowledge. Here `vec_o` names the wrong line one cycle later, or `isr_o` gains the wrong bit on that same edge. An in-service bit that was not released, or a base that did not rotate, shows only indirectly at first: `irq_o` stays low one cycle later while a lower line is still pending. The stimulus therefore follows every state change with an idle cycle and checks the interrupt line against the pending pattern. The sequence also moves the base through several positions, so that modulo-wrap errors change which line wins.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int RPR_LINES = 8;

    typedef enum logic [2:0] {
        OP_EOI_TOP     = 3'd0,
        OP_EOI_LINE    = 3'd1,
        OP_EOI_TOP_ROT = 3'd2,
        OP_EOI_LINE_ROT = 3'd3,
        OP_SET_BASE    = 3'd4
    } rpr_op_e;
endpackage

// File: rtl/rpr_prio_pick.sv
// Finds the best rank of a bit vector on a ring that starts at base_i.
// prio_o == N means no bit is set; its top bit doubles as "none".
module rpr_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    input  logic [IW-1:0] base_i,
    output logic [IW:0]   prio_o
);
    logic [N-1:0] rot;

    for (genvar p = 0; p < N; p++) begin : g_rot
        assign rot[p] = bits_i[IW'(p) + base_i];
    end

    always_comb begin
        prio_o = (IW+1)'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (rot[p]) prio_o = (IW+1)'(p);
        end
    end
endmodule

// File: rtl/rpr_cmd_dec.sv
// Turns an end-of-interrupt / base command into a clear mask and base load.
module rpr_cmd_dec
    import rpr_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic [IW-1:0] line_i,
    input  logic          top_found_i,
    input  logic [IW-1:0] top_line_i,
    output logic [N-1:0]  clr_o,
    output logic          base_ld_o,
    output logic [IW-1:0] base_o
);
    localparam logic [N-1:0] ONE = N'(1);

    always_comb begin
        clr_o     = '0;
        base_ld_o = 1'b0;
        base_o    = '0;
        if (valid_i) begin
            case (rpr_op_e'(op_i))
                OP_EOI_TOP: begin
                    if (top_found_i) clr_o = ONE << top_line_i;
                end
                OP_EOI_TOP_ROT: begin
                    if (top_found_i) begin
                        clr_o     = ONE << top_line_i;
                        base_ld_o = 1'b1;
                        base_o    = top_line_i + 1'b1;
                    end
                end
                OP_EOI_LINE: clr_o = ONE << line_i;
                OP_EOI_LINE_ROT: begin
                    clr_o     = ONE << line_i;
                    base_ld_o = 1'b1;
                    base_o    = line_i + 1'b1;
                end
                OP_SET_BASE: begin
                    base_ld_o = 1'b1;
                    base_o    = line_i + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
#(
    parameter int N_LINES = RPR_LINES,
    parameter int VEC_W   = 8,
    parameter int NEST_LINE = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_LINES-1:0]    req_i,
    input  logic [N_LINES-1:0]    mask_i,
    input  logic [VEC_W-1:0]      vec_base_i,
    input  logic                  nest_mode_i,
    input  logic                  auto_eoi_i,
    input  logic                  rot_auto_eoi_i,
    input  logic                  ack_i,
    input  logic                  cmd_valid_i,
    input  logic [2:0]            cmd_op_i,
    input  logic [$clog2(N_LINES)-1:0] cmd_line_i,
    output logic                  irq_o,
    output logic                  vec_valid_o,
    output logic [VEC_W-1:0]      vec_o,
    output logic                  spurious_o,
    output logic [N_LINES-1:0]    isr_o,
    output logic [$clog2(N_LINES)-1:0] base_o
);
    localparam int IDX_W = $clog2(N_LINES);
    localparam logic [N_LINES-1:0] ONE      = N_LINES'(1);
    localparam logic [N_LINES-1:0] NEST_BIT = ONE << NEST_LINE;
    localparam logic [VEC_W-1:0]   LOW_MASK = VEC_W'(N_LINES - 1);

    typedef struct packed {
        logic [N_LINES-1:0] isr;
        logic [IDX_W-1:0]   base;
        logic               irq;
        logic               vec_vld;
        logic [VEC_W-1:0]   vec;
        logic               spur;
    } st_t;

    st_t st_d, st_q;

    logic [N_LINES-1:0] pend, isr_cmp, win_1h, cmd_clr;
    logic [IDX_W:0]     pend_prio, cmp_prio, top_prio;
    logic [IDX_W-1:0]   win_line, top_line, cmd_base;
    logic               win_ok, top_found, cmd_base_ld;
    logic [VEC_W-1:0]   vec_hi;

    assign pend    = req_i & ~mask_i;
    assign isr_cmp = nest_mode_i ? (st_q.isr & ~NEST_BIT) : st_q.isr;

    rpr_prio_pick #(.N(N_LINES), .IW(IDX_W)) u_pick_pend (
        .bits_i (pend),
        .base_i (st_q.base),
        .prio_o (pend_prio)
    );

    rpr_prio_pick #(.N(N_LINES), .IW(IDX_W)) u_pick_cmp (
        .bits_i (isr_cmp),
        .base_i (st_q.base),
        .prio_o (cmp_prio)
    );

    rpr_prio_pick #(.N(N_LINES), .IW(IDX_W)) u_pick_top (
        .bits_i (st_q.isr),
        .base_i (st_q.base),
        .prio_o (top_prio)
    );

    assign win_ok    = (pend_prio < cmp_prio);
    assign win_line  = pend_prio[IDX_W-1:0] + st_q.base;
    assign win_1h    = ONE << win_line;
    assign top_found = ~top_prio[IDX_W];
    assign top_line  = top_prio[IDX_W-1:0] + st_q.base;
    assign vec_hi    = vec_base_i & ~LOW_MASK;

    rpr_cmd_dec #(.N(N_LINES), .IW(IDX_W)) u_cmd (
        .valid_i     (cmd_valid_i),
        .op_i        (cmd_op_i),
        .line_i      (cmd_line_i),
        .top_found_i (top_found),
        .top_line_i  (top_line),
        .clr_o       (cmd_clr),
        .base_ld_o   (cmd_base_ld),
        .base_o      (cmd_base)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq     = win_ok;
        st_d.vec_vld = 1'b0;
        if (ack_i) begin
            st_d.vec_vld = 1'b1;
            if (win_ok) begin
                st_d.vec  = vec_hi | VEC_W'(win_line);
                st_d.spur = 1'b0;
                if (auto_eoi_i) begin
                    st_d.isr = st_q.isr & ~win_1h;
                    if (rot_auto_eoi_i) st_d.base = win_line + 1'b1;
                end else begin
                    st_d.isr = st_q.isr | win_1h;
                end
            end else begin
                st_d.vec  = vec_hi | LOW_MASK;
                st_d.spur = 1'b1;
            end
        end else if (cmd_valid_i) begin
            st_d.isr = st_q.isr & ~cmd_clr;
            if (cmd_base_ld) st_d.base = cmd_base;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o       = st_q.irq;
    assign vec_valid_o = st_q.vec_vld;
    assign vec_o       = st_q.vec;
    assign spurious_o  = st_q.spur;
    assign isr_o       = st_q.isr;
    assign base_o      = st_q.base;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  mask_i,
    input logic          auto_eoi_i,
    input logic          ack_i,
    input logic          cmd_valid_i,
    input logic          irq_o,
    input logic          vec_valid_o,
    input logic [IW-1:0] vec_low,
    input logic          spurious_o,
    input logic [N-1:0]  isr_o,
    input logic [IW-1:0] base_o
);
    // Acknowledge and command are exclusive (protocol rule of R5)
    assert_ack_cmd_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_i && cmd_valid_i));

    assert_isr_set_only_by_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(isr_o & ~$past(isr_o))) |-> $past(ack_i));

    assert_vec_valid_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> vec_valid_o);

    assert_vec_valid_only_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_i |=> !vec_valid_o);

    assert_spurious_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && spurious_o) |-> (vec_low == {IW{1'b1}}));

    assert_auto_eoi_no_isr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && auto_eoi_i) |=> !(|(isr_o & ~$past(isr_o))));

    assert_base_needs_event_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_o != $past(base_o)) |-> $past(ack_i || cmd_valid_i));

    assert_irq_needs_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|(req_i & ~mask_i)));
endmodule

bind rot_prio_resolver rpr_checker #(.N(N_LINES), .IW(IDX_W)) u_rpr_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mask_i      (mask_i),
    .auto_eoi_i  (auto_eoi_i),
    .ack_i       (ack_i),
    .cmd_valid_i (cmd_valid_i),
    .irq_o       (irq_o),
    .vec_valid_o (vec_valid_o),
    .vec_low     (vec_o[IDX_W-1:0]),
    .spurious_o  (spurious_o),
    .isr_o       (isr_o),
    .base_o      (base_o)
);

// File: tb/rot_prio_resolver_bench.sv
module rot_prio_resolver_bench;
    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic [7:0] req_i, mask_i, vec_base_i;
    logic       nest_mode_i, auto_eoi_i, rot_auto_eoi_i;
    logic       ack_i, cmd_valid_i;
    logic [2:0] cmd_op_i, cmd_line_i;
    logic       irq_o, vec_valid_o, spurious_o;
    logic [7:0] vec_o, isr_o;
    logic [2:0] base_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk_i = ~clk_i;

    rot_prio_resolver u_rot_prio_resolver (
        .clk_i, .rst_ni, .req_i, .mask_i, .vec_base_i, .nest_mode_i,
        .auto_eoi_i, .rot_auto_eoi_i, .ack_i, .cmd_valid_i, .cmd_op_i,
        .cmd_line_i, .irq_o, .vec_valid_o, .vec_o, .spurious_o, .isr_o, .base_o
    );

    typedef struct packed {
        logic       ack;
        logic [7:0] req;
        logic [7:0] mask;
        logic [2:0] op;
        logic [2:0] line;
        logic       nest;
        logic       aeoi;
        logic       raeoi;
        logic [7:0] e_vec;
        logic       e_spur;
        logic [7:0] e_isr;
        logic [2:0] e_base;
        logic       e_irq;
        logic [3:0] rq;
    } step_t;

    localparam int NSTEP = 21;
    // vec_base_i is 0x45, so vectors sit at 0x40 + line
    localparam step_t TBL [NSTEP] = '{
        '{1'b1,8'h28,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h43,1'b0,8'h08,3'd0,1'b0,4'd5},  // R5 line 3 beats 5; R3 no irq for 5
        '{1'b1,8'h20,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h47,1'b1,8'h08,3'd0,1'b0,4'd6},  // R6 blocked by in-service 3
        '{1'b1,8'h05,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h40,1'b0,8'h09,3'd0,1'b0,4'd3},  // R3 line 0 preempts
        '{1'b0,8'h05,8'h00,3'd0,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h08,3'd0,1'b1,4'd8},  // R8 clears line 0
        '{1'b0,8'h05,8'h00,3'd2,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd4,1'b1,4'd9},  // R9 clears 3, base 4
        '{1'b1,8'h05,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h40,1'b0,8'h01,3'd4,1'b0,4'd2},  // R2 base 4: 0 beats 2
        '{1'b1,8'h90,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h44,1'b0,8'h11,3'd4,1'b0,4'd2},  // R2 line 4 rank 0
        '{1'b0,8'h90,8'h00,3'd1,3'd4,1'b0,1'b0,1'b0,8'h00,1'b0,8'h01,3'd4,1'b1,4'd10}, // R10 specific clear
        '{1'b0,8'h90,8'h00,3'd3,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd1,1'b1,4'd10}, // R10 specific rotate
        '{1'b0,8'h90,8'h00,3'd4,3'd6,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd7,1'b1,4'd11}, // R11 base 7
        '{1'b1,8'h90,8'h80,3'd7,3'd0,1'b0,1'b0,1'b0,8'h44,1'b0,8'h10,3'd7,1'b0,4'd2},  // R2 line 7 masked
        '{1'b1,8'h02,8'h00,3'd7,3'd0,1'b0,1'b1,1'b1,8'h41,1'b0,8'h10,3'd2,1'b0,4'd7},  // R7 auto + rotate
        '{1'b1,8'h08,8'h00,3'd7,3'd0,1'b0,1'b1,1'b0,8'h43,1'b0,8'h10,3'd2,1'b1,4'd7},  // R7 auto, no rotate
        '{1'b0,8'h00,8'h00,3'd0,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd2,1'b0,4'd8},  // R8 clears line 4
        '{1'b0,8'h00,8'h00,3'd2,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd2,1'b0,4'd9},  // R9 empty: no change
        '{1'b0,8'h00,8'h00,3'd4,3'd7,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd0,1'b0,4'd11}, // R11 wrap to 0
        '{1'b1,8'h04,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h42,1'b0,8'h04,3'd0,1'b0,4'd3},  // R3 equal rank blocks
        '{1'b0,8'h04,8'h00,3'd7,3'd0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h04,3'd0,1'b1,4'd4},  // R4 nest; R12 no-op code
        '{1'b1,8'h04,8'h00,3'd7,3'd0,1'b1,1'b0,1'b0,8'h42,1'b0,8'h04,3'd0,1'b1,4'd4},  // R4 nested re-entry
        '{1'b0,8'h04,8'h00,3'd0,3'd0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,3'd0,1'b1,4'd8},  // R8 ignores nest mode
        '{1'b1,8'h00,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h47,1'b1,8'h00,3'd0,1'b0,4'd6}   // R6 nothing pending
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_step(input step_t s);
        req_i = s.req; mask_i = s.mask; nest_mode_i = s.nest;
        auto_eoi_i = s.aeoi; rot_auto_eoi_i = s.raeoi;
        ack_i = s.ack; cmd_valid_i = ~s.ack; cmd_op_i = s.op; cmd_line_i = s.line;
        @(negedge clk_i);
        ack_i = 1'b0; cmd_valid_i = 1'b0;
        chk($sformatf("R%0d vec_valid", s.rq), 32'(vec_valid_o), 32'(s.ack));
        if (s.ack) begin
            chk($sformatf("R%0d vec", s.rq), 32'(vec_o), 32'(s.e_vec));
            chk($sformatf("R%0d spurious", s.rq), 32'(spurious_o), 32'(s.e_spur));
        end
        @(negedge clk_i);
        chk($sformatf("R%0d isr", s.rq), 32'(isr_o), 32'(s.e_isr));
        chk($sformatf("R%0d base", s.rq), 32'(base_o), 32'(s.e_base));
        chk($sformatf("R%0d irq", s.rq), 32'(irq_o), 32'(s.e_irq));
    endtask

    task automatic check_reset_state();
        chk("R1 isr", 32'(isr_o), 32'h0);
        chk("R1 base", 32'(base_o), 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 vec_valid", 32'(vec_valid_o), 32'h0);
    endtask

    initial begin
        repeat (5000) @(posedge clk_i);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_ni = 1'b0; req_i = '0; mask_i = '0; vec_base_i = 8'h45;
        nest_mode_i = 1'b0; auto_eoi_i = 1'b0; rot_auto_eoi_i = 1'b0;
        ack_i = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_line_i = '0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        check_reset_state();  // R1 after release

        for (int i = 0; i < NSTEP; i++) run_step(TBL[i]);

        // R11 then R5: build nonzero state, then R1 on a mid-run reset
        run_step('{1'b0,8'h00,8'h00,3'd4,3'd2,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd3,1'b0,4'd11});
        run_step('{1'b1,8'h10,8'h00,3'd7,3'd0,1'b0,1'b0,1'b0,8'h44,1'b0,8'h10,3'd3,1'b0,4'd5});
        req_i = 8'h01;
        rst_ni = 1'b0;
        @(negedge clk_i);
        check_reset_state();
        rst_ni = 1'b1;
        req_i = '0;
        @(negedge clk_i);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule